// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator with Inbound DMA Window

This block turns a 24-bit virtual address into a physical address in two lookups. The first lookup reads a segment table. The segment table is indexed by the current context number together with the top bits of the virtual address. A segment entry holds a pointer into the page table and a three-bit protection code. The second lookup reads the page table, indexed by that pointer together with the next virtual address bits. It yields a physical page number, and the untranslated offset bits are appended to that number.

Both tables are synchronous RAMs. The processor loads them by writing into two address regions of its register port. The block also serves a second requester: an external bus master whose memory commands fall in the upper half of the bus address space. Such a command is steered through the same tables, always under the highest context number and always into the top quarter of the segments. This lets an outside controller reach local memory through a mapping that software controls.

The processor has priority on the tables. A DMA lookup whose check fails is simply never acknowledged, so the external master's own timeout ends the transfer.

Top module: `seg_page_mmu`

## Requirements
- R1: A processor request (`cpu_req` high in a cycle) produces `cpu_done` exactly two cycles later. The segment entry used is at index {`cpu_ctx`, VA[23:18]}. The page entry used is at index {segment pointer, VA[17:14]}. The result is `cpu_pa` = {page number, VA[13:0]}.
- R2: Access types are encoded as 0 = read, 1 = write, 2 = execute; code 3 is always refused. The protection codes are:
  - 0: no rights for either mode.
  - 1: supervisor read only.
  - 2: supervisor read and write.
  - 3: supervisor read and execute.
  - 4: supervisor read and write, user read.
  - 5: full supervisor rights, no user rights.
  - 6: full supervisor rights, user read and execute.
  - 7: full rights in both modes.
- R3: When the access is not permitted by the segment's code for the given mode (`cpu_sup` = 1 is supervisor), `cpu_fault` is high together with `cpu_done`; otherwise it is low.
- R4: A register-port write with `cfg_addr[23:21]` = 3'b110 (region 0xC00000–0xDFFFFF) loads segment entry {`cpu_ctx`, `cfg_addr[6:1]`}, with the pointer from `cfg_wdata[5:0]` and the code from `cfg_wdata[8:6]`. A write with `cfg_addr[23:21]` = 3'b101 (region 0xA00000–0xBFFFFF) loads page entry `cfg_addr[10:1]` with `cfg_wdata[9:0]`. Writes to any other region change nothing.
- R5: A DMA command is inside the window when `dma_addr[23]` is 1 with `dma_wide` = 1, or when `dma_addr[23:20]` = 0 and `dma_addr[19]` = 1 with `dma_wide` = 0. A command outside the window starts no lookup and is never acknowledged.
- R6: A DMA lookup uses virtual address {2'b11, addr[21:0]} in wide mode and {2'b11, 3'b000, addr[18:0]} in narrow mode, so it only reaches segments 48–63. It is checked as a supervisor access, a write when `dma_wr` = 1 and a read otherwise.
- R7: An allowed DMA lookup gives a one-cycle `dma_ack` carrying `dma_pa`, two cycles after launch. A refused lookup gives no acknowledge.
- R8: A DMA lookup launches only in a cycle without `cpu_req`. A DMA command arriving alongside a processor request is acknowledged one cycle later than it would be otherwise, and the processor result is not delayed.
- R9: A DMA command held high after its acknowledge is translated only once, and receives no further acknowledge until `dma_req` falls.
- R10: DMA lookups always use context 15, whatever value `cpu_ctx` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ctx | input | 4 | Current processor context; also selects the context for segment-table writes |
| cpu_req | input | 1 | Processor translation request |
| cpu_va | input | 24 | Processor virtual address |
| cpu_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| cpu_sup | input | 1 | 1 = supervisor mode |
| cpu_done | output | 1 | Processor result valid |
| cpu_fault | output | 1 | Processor access refused |
| cpu_pa | output | 24 | Processor physical address |
| cfg_we | input | 1 | Register-port write strobe |
| cfg_addr | input | 24 | Register-port address |
| cfg_wdata | input | 10 | Register-port write data |
| dma_req | input | 1 | DMA memory command, held until acknowledged or timed out |
| dma_wr | input | 1 | 1 = DMA write, 0 = DMA read |
| dma_wide | input | 1 | 1 = 24-bit bus mode, 0 = 20-bit bus mode |
| dma_addr | input | 24 | DMA bus address |
| dma_ack | output | 1 | DMA transfer acknowledge pulse |
| dma_pa | output | 24 | DMA physical address |

## Verification
The bench uses the default parameters: 16 contexts, 64 segments and 1024-entry tables. At these sizes it can fill every entry of both tables with random content. Random lookups then test the full index arithmetic, and the DMA segments 48–63 share the table with ordinary contexts. With a 20-bit narrow window, narrow DMA reaches only segments 48 and 49. This makes the window edges and the high-bit rejection easy to hit directly, and it lets a read-only segment be tested against DMA writes.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  localparam logic [2:0] REGION_PAGE = 3'b101;
  localparam logic [2:0] REGION_SEG  = 3'b110;

  // Returns {supervisor r,w,x, user r,w,x} for a protection code.
  function automatic logic [5:0] prot_rights(input logic [2:0] code);
    case (code)
      3'd0:    prot_rights = 6'b000_000;
      3'd1:    prot_rights = 6'b100_000;
      3'd2:    prot_rights = 6'b110_000;
      3'd3:    prot_rights = 6'b101_000;
      3'd4:    prot_rights = 6'b110_100;
      3'd5:    prot_rights = 6'b111_000;
      3'd6:    prot_rights = 6'b111_101;
      default: prot_rights = 6'b111_111;
    endcase
  endfunction

  function automatic logic prot_allows(input logic [2:0] code, input logic sup, input acc_e acc);
    logic [5:0] r;
    logic [2:0] set;
    r   = prot_rights(code);
    set = sup ? r[5:3] : r[2:0];
    case (acc)
      ACC_READ:  prot_allows = set[2];
      ACC_WRITE: prot_allows = set[1];
      ACC_EXEC:  prot_allows = set[0];
      default:   prot_allows = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mmu_map_ram.sv
module mmu_map_ram #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mmu_issue.sv
module mmu_issue #(
  parameter int VA_W     = 24,
  parameter int NARROW_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            dma_req,
  input  logic            dma_wr,
  input  logic            dma_wide,
  input  logic [VA_W-1:0] dma_addr,
  output logic            dma_go,
  output logic            dma_win_hit,
  output logic            dma_busy,
  output logic [VA_W-1:0] dma_va,
  output logic [1:0]      dma_acc
);
  import mmu_pkg::*;

  localparam int PAD_W = VA_W - NARROW_W - 1;

  function automatic logic in_window(input logic [VA_W-1:0] a, input logic wide);
    if (wide) in_window = a[VA_W-1];
    else      in_window = (a[VA_W-1:NARROW_W] == '0) && a[NARROW_W-1];
  endfunction

  function automatic logic [VA_W-1:0] window_va(input logic [VA_W-1:0] a, input logic wide);
    if (wide) window_va = {2'b11, a[VA_W-3:0]};
    else      window_va = {2'b11, {PAD_W{1'b0}}, a[NARROW_W-2:0]};
  endfunction

  assign dma_win_hit = dma_req && in_window(dma_addr, dma_wide);
  assign dma_go      = dma_win_hit && !dma_busy && !cpu_req;
  assign dma_va      = window_va(dma_addr, dma_wide);
  assign dma_acc     = dma_wr ? ACC_WRITE : ACC_READ;

  always_ff @(posedge clk) begin
    if (!rst_n)        dma_busy <= 1'b0;
    else if (dma_go)   dma_busy <= 1'b1;
    else if (!dma_req) dma_busy <= 1'b0;
  end

  // R9: a launched command stays marked until its request falls
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && dma_req) |=> dma_busy);
endmodule

// File: rtl/seg_page_mmu.sv
module seg_page_mmu #(
  parameter int VA_W     = 24,
  parameter int CTX_W    = 4,
  parameter int SEG_W    = 6,
  parameter int PG_W     = 4,
  parameter int PMEG_W   = 6,
  parameter int PPN_W    = 10,
  parameter int NARROW_W = 20,
  localparam int OFF_W   = VA_W - SEG_W - PG_W,
  localparam int PA_W    = PPN_W + OFF_W,
  localparam int SEG_DW  = PMEG_W + 3,
  localparam int CFG_DW  = (PPN_W > SEG_DW) ? PPN_W : SEG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  cpu_ctx,
  input  logic              cpu_req,
  input  logic [VA_W-1:0]   cpu_va,
  input  logic [1:0]        cpu_acc,
  input  logic              cpu_sup,
  output logic              cpu_done,
  output logic              cpu_fault,
  output logic [PA_W-1:0]   cpu_pa,
  input  logic              cfg_we,
  input  logic [VA_W-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              dma_req,
  input  logic              dma_wr,
  input  logic              dma_wide,
  input  logic [VA_W-1:0]   dma_addr,
  output logic              dma_ack,
  output logic [PA_W-1:0]   dma_pa
);
  import mmu_pkg::*;

  localparam int SEG_AW = CTX_W + SEG_W;
  localparam int PG_AW  = PMEG_W + PG_W;

  // issue stage
  logic            dma_go, dma_win_hit, dma_busy;
  logic [VA_W-1:0] dma_va;
  logic [1:0]      dma_acc;

  mmu_issue #(.VA_W(VA_W), .NARROW_W(NARROW_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
    .dma_wr(dma_wr), .dma_wide(dma_wide), .dma_addr(dma_addr),
    .dma_go(dma_go), .dma_win_hit(dma_win_hit), .dma_busy(dma_busy),
    .dma_va(dma_va), .dma_acc(dma_acc)
  );

  logic             issue_vld;
  logic [VA_W-1:0]  sel_va;
  logic [CTX_W-1:0] sel_ctx;
  logic [1:0]       sel_acc;
  logic             sel_sup;

  assign issue_vld = cpu_req || dma_go;
  assign sel_va    = cpu_req ? cpu_va  : dma_va;
  assign sel_ctx   = cpu_req ? cpu_ctx : {CTX_W{1'b1}};
  assign sel_acc   = cpu_req ? cpu_acc : dma_acc;
  assign sel_sup   = cpu_req ? cpu_sup : 1'b1;

  // register-port decode
  logic              seg_we, pg_we;
  logic [SEG_AW-1:0] seg_waddr;
  logic [PG_AW-1:0]  pg_waddr;
  logic              unused_cfg_bits;

  assign seg_we    = cfg_we && (cfg_addr[VA_W-1 -: 3] == REGION_SEG);
  assign pg_we     = cfg_we && (cfg_addr[VA_W-1 -: 3] == REGION_PAGE);
  assign seg_waddr = {cpu_ctx, cfg_addr[SEG_W:1]};
  assign pg_waddr  = cfg_addr[PG_AW:1];
  assign unused_cfg_bits = ^{cfg_addr[VA_W-4:PG_AW+1], cfg_addr[0]};

  // stage 1: segment lookup
  logic              s1_vld, s1_cpu, s1_sup;
  logic [PG_W-1:0]   s1_page;
  logic [OFF_W-1:0]  s1_off;
  logic [1:0]        s1_acc;
  logic [SEG_DW-1:0] seg_rd;

  mmu_map_ram #(.AW(SEG_AW), .DW(SEG_DW)) u_seg_map (
    .clk(clk), .we(seg_we), .waddr(seg_waddr), .wdata(cfg_wdata[SEG_DW-1:0]),
    .re(issue_vld), .raddr({sel_ctx, sel_va[VA_W-1 -: SEG_W]}), .rdata(seg_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= issue_vld;
    s1_cpu  <= cpu_req;
    s1_sup  <= sel_sup;
    s1_acc  <= sel_acc;
    s1_page <= sel_va[OFF_W +: PG_W];
    s1_off  <= sel_va[OFF_W-1:0];
  end

  logic [PMEG_W-1:0] seg_pmeg;
  logic [2:0]        seg_prot;
  assign seg_pmeg = seg_rd[PMEG_W-1:0];
  assign seg_prot = seg_rd[SEG_DW-1 -: 3];

  // stage 2: page lookup and protection check
  logic             s2_vld, s2_cpu, s2_fault;
  logic [OFF_W-1:0] s2_off;
  logic [PPN_W-1:0] pg_rd;

  mmu_map_ram #(.AW(PG_AW), .DW(PPN_W)) u_page_map (
    .clk(clk), .we(pg_we), .waddr(pg_waddr), .wdata(cfg_wdata[PPN_W-1:0]),
    .re(s1_vld), .raddr({seg_pmeg, s1_page}), .rdata(pg_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
    s2_cpu   <= s1_cpu;
    s2_off   <= s1_off;
    s2_fault <= !prot_allows(seg_prot, s1_sup, acc_e'(s1_acc));
  end

  assign cpu_done  = s2_vld && s2_cpu;
  assign cpu_fault = cpu_done && s2_fault;
  assign cpu_pa    = {pg_rd, s2_off};
  assign dma_ack   = s2_vld && !s2_cpu && !s2_fault;
  assign dma_pa    = {pg_rd, s2_off};

  // R1: processor request enters stage 1, then completes
  a_r1_cpu_enters: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |=> (s1_vld && s1_cpu));
  a_r1_cpu_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_cpu) |=> cpu_done);
  // R5: a DMA lookup in flight came from an in-window command
  a_r5_launch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_cpu) |-> $past(dma_win_hit));
  // R7: acknowledge only for a launched command
  a_r7_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> dma_busy);
  // R8: one result slot per cycle
  a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_done, dma_ack}));
  // R9: acknowledge is a single pulse
  a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_ack);
endmodule

// File: tb/seg_page_mmu_tb.sv
module seg_page_mmu_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  cpu_ctx;
  logic        cpu_req, cpu_sup;
  logic [23:0] cpu_va;
  logic [1:0]  cpu_acc;
  logic        cpu_done, cpu_fault;
  logic [23:0] cpu_pa;
  logic        cfg_we;
  logic [23:0] cfg_addr;
  logic [9:0]  cfg_wdata;
  logic        dma_req, dma_wr, dma_wide, dma_ack;
  logic [23:0] dma_addr, dma_pa;

  seg_page_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_ctx(cpu_ctx), .cpu_req(cpu_req), .cpu_va(cpu_va),
    .cpu_acc(cpu_acc), .cpu_sup(cpu_sup), .cpu_done(cpu_done), .cpu_fault(cpu_fault),
    .cpu_pa(cpu_pa), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dma_req(dma_req), .dma_wr(dma_wr), .dma_wide(dma_wide), .dma_addr(dma_addr),
    .dma_ack(dma_ack), .dma_pa(dma_pa)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit [8:0] seg_m [1024];
  bit [9:0] pg_m  [1024];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench view of the protection table
  function automatic bit allowed(input bit [2:0] c, input bit sup, input bit [1:0] acc);
    bit r, w, x;
    if (sup) begin
      r = (c != 0); w = (c inside {2, 4, 5, 6, 7}); x = (c inside {3, 5, 6, 7});
    end else begin
      r = (c inside {4, 6, 7}); w = (c == 7); x = (c inside {6, 7});
    end
    return (acc == 0) ? r : (acc == 1) ? w : (acc == 2) ? x : 1'b0;
  endfunction

  function automatic bit [23:0] model_pa(input bit [3:0] ctx, input bit [23:0] va);
    bit [5:0] pm = seg_m[{ctx, va[23:18]}][5:0];
    return {pg_m[{pm, va[17:14]}], va[13:0]};
  endfunction

  task automatic wr_seg(input bit [3:0] ctx, input bit [5:0] seg, input bit [2:0] code, input bit [5:0] pm);
    cpu_ctx = ctx; cfg_we = 1; cfg_addr = 24'hC00000 | (24'(seg) << 1);
    cfg_wdata = {1'b0, code, pm};
    seg_m[{ctx, seg}] = {code, pm};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_pg(input bit [9:0] idx, input bit [9:0] ppn);
    cfg_we = 1; cfg_addr = 24'hA00000 | (24'(idx) << 1); cfg_wdata = ppn;
    pg_m[idx] = ppn;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cpu_xlate(input bit [3:0] ctx, input bit [23:0] va, input bit [1:0] acc,
                           input bit sup, input string tag);
    bit ok;
    cpu_ctx = ctx; cpu_va = va; cpu_acc = acc; cpu_sup = sup; cpu_req = 1;
    @(negedge clk); cpu_req = 0;
    @(negedge clk);
    ok = allowed(seg_m[{ctx, va[23:18]}][8:6], sup, acc);
    check(cpu_done == 1, {tag, " R1 done"}, 32'(cpu_done), 1);
    check(cpu_fault == !ok, {tag, " R3 fault"}, 32'(cpu_fault), 32'(!ok));
    if (ok) check(cpu_pa == model_pa(ctx, va), {tag, " R1 pa"}, cpu_pa, model_pa(ctx, va));
  endtask

  task automatic dma_xfer(input bit [23:0] a, input bit wr, input bit wide, input bit collide,
                          input string tag);
    bit in_win, exp_ack;
    bit [23:0] va;
    int acks = 0, lat = 0;
    logic [23:0] got = '0;
    in_win = wide ? (a >= 24'h800000) : (a >= 24'h080000 && a < 24'h100000);
    va = wide ? (24'hC00000 | (a & 24'h3FFFFF)) : (24'hC00000 | (a & 24'h07FFFF));
    exp_ack = in_win && allowed(seg_m[{4'hF, va[23:18]}][8:6], 1'b1, {1'b0, wr});
    cpu_ctx = 4'($urandom_range(0, 14));   // R10: DMA must ignore this
    dma_addr = a; dma_wr = wr; dma_wide = wide; dma_req = 1;
    if (collide) begin cpu_va = 24'h123456; cpu_acc = 0; cpu_sup = 1; cpu_req = 1; end
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      cpu_req = 0;
      if (dma_ack) begin
        acks++;
        if (lat == 0) begin lat = k; got = dma_pa; end
      end
    end
    dma_req = 0;
    @(negedge clk);
    if (exp_ack) begin
      check(acks == 1, {tag, " R9 one ack"}, 32'(acks), 1);
      check(lat == (collide ? 3 : 2), {tag, " R8 latency"}, 32'(lat), collide ? 3 : 2);
      check(got == model_pa(4'hF, va), {tag, " R6 R10 pa"}, got, model_pa(4'hF, va));
    end else begin
      check(acks == 0, {tag, " R5 R7 no ack"}, 32'(acks), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cpu_ctx = 0; cpu_req = 0; cpu_va = 0; cpu_acc = 0; cpu_sup = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    dma_req = 0; dma_wr = 0; dma_wide = 0; dma_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cpu_done == 0, "reset R1 done", 32'(cpu_done), 0);
    check(dma_ack == 0, "reset R7 ack", 32'(dma_ack), 0);

    // R4: fill both tables through the register port
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 64; s++)
        wr_seg(4'(c), 6'(s), 3'($urandom_range(0, 7)), 6'($urandom_range(0, 63)));
    for (int i = 0; i < 1024; i++) wr_pg(10'(i), 10'($urandom));

    // R1 R2 R3: random processor lookups
    for (int n = 0; n < 300; n++)
      cpu_xlate(4'($urandom), 24'($urandom), 2'($urandom), 1'($urandom), "rand");

    // R2: code 5 gives full supervisor rights and no user rights
    wr_seg(4'd3, 6'd10, 3'd5, 6'd17);
    for (int acc = 0; acc < 3; acc++) cpu_xlate(4'd3, 24'h28ABCD, 2'(acc), 1'b1, "code5 sup R2");
    cpu_xlate(4'd3, 24'h28ABCD, 2'd0, 1'b0, "code5 user R2");
    cpu_xlate(4'd3, 24'h28ABCD, 2'd3, 1'b1, "acc3 R2");

    // R4: writes outside both regions are ignored
    cpu_ctx = 4'd3; cfg_we = 1; cfg_addr = 24'hE00000 | (24'd10 << 1); cfg_wdata = 10'h000;
    @(negedge clk);
    cfg_addr = 24'h000000 | (24'd10 << 1);
    @(negedge clk);
    cfg_addr = 24'h800000 | (24'd10 << 1); cfg_wdata = 10'h3FF;
    @(negedge clk); cfg_we = 0;
    cpu_xlate(4'd3, 24'h28ABCD, 2'd1, 1'b1, "ignored write R4");

    // R5 R6 R7: directed window edges under context 15
    wr_seg(4'hF, 6'd48, 3'd5, 6'd5);
    wr_seg(4'hF, 6'd63, 3'd5, 6'd6);
    wr_seg(4'hF, 6'd49, 3'd1, 6'd7);
    dma_xfer(24'h800000, 0, 1, 0, "wide low edge");
    dma_xfer(24'hFFFFFF, 1, 1, 0, "wide high edge");
    dma_xfer(24'h7FFFFF, 0, 1, 0, "wide below");
    dma_xfer(24'h080000, 1, 0, 0, "narrow low edge");
    dma_xfer(24'h07FFFF, 0, 0, 0, "narrow below");
    dma_xfer(24'h180000, 0, 0, 0, "narrow high bits");
    dma_xfer(24'h0C0000, 1, 0, 0, "readonly write R7");
    dma_xfer(24'h0C0000, 0, 0, 0, "readonly read R7");
    dma_xfer(24'h800000, 0, 1, 1, "collide R8");

    // random DMA, some colliding with processor requests
    for (int n = 0; n < 200; n++) begin
      bit wide = 1'($urandom);
      bit [23:0] a = wide ? 24'($urandom) : (n % 10 == 0 ? 24'($urandom) : 24'($urandom_range(0, 24'hFFFFF)));
      dma_xfer(a, 1'($urandom), wide, (n % 7 == 0), "rand dma");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule